// File: doc/BRIEF.md
# Dual-Source Interrupt Status Controller

This block gathers single-cycle event pulses from two producers, a hash engine and the DMA engine that feeds it, into two banks of sticky status bits. Each bank has its own enable register that selects which latched bits may raise the interrupt. The DMA bank also sits behind a one-bit global unmask register. The two gated banks are ORed onto a single level-sensitive interrupt line.

Software reaches the banks through a small 32-bit register bus. A status bit stays set until software writes a 1 to it. Reads return the raw latched bits whatever the enable setting, so a handler can read a bank, write the same value back to acknowledge it, and then tell completion from error by bit position.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After synchronous reset, both status banks, both enable registers and the unmask register are zero, `irq` is low and reads of every register return 0.
- R2: A pulse on `hash_evt[i]` (bit 2 = hash done, bits 0, 1 and 3 = hash errors) sets hash status bit i at the next clock edge, even when that bit is disabled. The bit then holds until it is cleared, and a read of the hash status register (offset 0x050) returns the raw bits in [3:0].
- R3: A pulse on `dma_evt[i]` sets DMA status bit i (bit 0 = source transfer done, bits 2..8 = error conditions). Bit 1 and bits 31..9 are reserved: they never set and always read 0 at the DMA status offset 0x480.
- R4: A write to a status offset clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFFFFFF clears every pending bit of that bank.
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: The enable registers (hash at 0x054, DMA at 0x484) store the written value for their implemented bits only (hash [3:0], DMA bits 0 and 2..8) and read it back. Writing 0 to an enable register removes that whole bank from `irq`.
- R7: `irq` is high exactly when (hash status AND hash enable) is nonzero, or when (DMA status AND DMA enable) is nonzero and the unmask bit is 1. It follows register state with no added delay.
- R8: The unmask register at 0x488 stores bit 0 only, and reads return 0 in bits 31..1. While it is 0, DMA status never raises `irq`, whatever the DMA enable setting.
- R9: A read of any other offset returns 0, and a write to any other offset changes no register.
- R10: Read data appears on `bus_rdata` one cycle after the read request and shows the register value from before that clock edge. In cycles with no read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hash_evt | input | 4 | Hash engine event pulses (done / error) |
| dma_evt | input | 9 | DMA engine event pulses (done / error) |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read request |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench hits one bit with an event pulse and a clearing write in the same cycle. A design that lets the clear win would lose an event that arrived during acknowledge, and would read 0 where 0x004 is expected. It writes 0 to status registers and checks that the bits survive, which catches a clear-on-any-write. It clears single bits out of a mixed pattern, which catches a whole-register clear. It walks the DMA bank through enable-without-unmask, unmask, and enable-zero, so a design that ignores the global mask, or gates on enable before latching, drives `irq` at the wrong time. Reserved DMA bit 1 and unmapped offsets are also read back, so stray flops or aliased decode show up as nonzero data.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int HASH_W = 4;
    localparam int DMA_W  = 9;

    // register offsets
    localparam int unsigned OFS_HASH_STAT = 32'h050;
    localparam int unsigned OFS_HASH_EN   = 32'h054;
    localparam int unsigned OFS_DMA_STAT  = 32'h480;
    localparam int unsigned OFS_DMA_EN    = 32'h484;
    localparam int unsigned OFS_DMA_UNMSK = 32'h488;

    // implemented bits per bank
    localparam logic [HASH_W-1:0] HASH_IMPL = 4'b1111;
    localparam logic [DMA_W-1:0]  DMA_IMPL  = 9'b1_1111_1101;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_HASH_STAT,
        RS_HASH_EN,
        RS_DMA_STAT,
        RS_DMA_EN,
        RS_DMA_UNMSK
    } reg_sel_e;

    typedef struct packed {
        logic hash_stat;
        logic hash_en;
        logic dma_stat;
        logic dma_en;
        logic dma_unmsk;
    } wr_stb_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        r = RS_NONE;
        if (a == ADDR_W'(OFS_HASH_STAT)) r = RS_HASH_STAT;
        if (a == ADDR_W'(OFS_HASH_EN))   r = RS_HASH_EN;
        if (a == ADDR_W'(OFS_DMA_STAT))  r = RS_DMA_STAT;
        if (a == ADDR_W'(OFS_DMA_EN))    r = RS_DMA_EN;
        if (a == ADDR_W'(OFS_DMA_UNMSK)) r = RS_DMA_UNMSK;
        return r;
    endfunction

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output reg_sel_e      rsel,
    output wr_stb_t       wstb,
    output logic          rd
);
    always_comb begin
        rsel = decode_ofs(ADDR_W'(addr));
        rd   = sel && !wr;
        wstb = '0;
        if (sel && wr) begin
            case (rsel)
                RS_HASH_STAT: wstb.hash_stat = 1'b1;
                RS_HASH_EN:   wstb.hash_en   = 1'b1;
                RS_DMA_STAT:  wstb.dma_stat  = 1'b1;
                RS_DMA_EN:    wstb.dma_en    = 1'b1;
                RS_DMA_UNMSK: wstb.dma_unmsk = 1'b1;
                default:      wstb = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int           W    = 4,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] en_q,
    output logic         pend
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (IMPL[i]) begin : g_impl
                logic s_q;
                logic e_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        s_q <= 1'b0;
                        e_q <= 1'b0;
                    end else begin
                        // a new event outranks a same-cycle clear
                        if (evt[i])
                            s_q <= 1'b1;
                        else if (clr_we && wdata[i])
                            s_q <= 1'b0;
                        if (en_we)
                            e_q <= wdata[i];
                    end
                end
                assign stat_q[i] = s_q;
                assign en_q[i]   = e_q;
            end else begin : g_rsv
                assign stat_q[i] = 1'b0;
                assign en_q[i]   = 1'b0;
            end
        end
    endgenerate

    assign pend = |(stat_q & en_q);
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BUS_W,
    parameter int HW = HASH_W,
    parameter int MW = DMA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hash_evt,
    input  logic [MW-1:0] dma_evt,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    reg_sel_e rsel;
    wr_stb_t  wstb;
    logic     rd;

    logic [HW-1:0] hash_stat, hash_en;
    logic [MW-1:0] dma_stat, dma_en;
    logic          hash_pend, dma_pend;
    logic          unmask_q;
    logic [DW-1:0] rd_mux;

    irqc_regdec #(.AW(AW)) u_dec (
        .sel (bus_sel),
        .wr  (bus_wr),
        .addr(bus_addr),
        .rsel(rsel),
        .wstb(wstb),
        .rd  (rd)
    );

    irqc_bank #(.W(HW), .IMPL(HW'(HASH_IMPL))) u_hash (
        .clk   (clk),
        .rst   (rst),
        .evt   (hash_evt),
        .clr_we(wstb.hash_stat),
        .en_we (wstb.hash_en),
        .wdata (bus_wdata[HW-1:0]),
        .stat_q(hash_stat),
        .en_q  (hash_en),
        .pend  (hash_pend)
    );

    irqc_bank #(.W(MW), .IMPL(MW'(DMA_IMPL))) u_dma (
        .clk   (clk),
        .rst   (rst),
        .evt   (dma_evt),
        .clr_we(wstb.dma_stat),
        .en_we (wstb.dma_en),
        .wdata (bus_wdata[MW-1:0]),
        .stat_q(dma_stat),
        .en_q  (dma_en),
        .pend  (dma_pend)
    );

    always_ff @(posedge clk) begin
        if (rst)
            unmask_q <= 1'b0;
        else if (wstb.dma_unmsk)
            unmask_q <= bus_wdata[0];
    end

    always_comb begin
        rd_mux = '0;
        case (rsel)
            RS_HASH_STAT: rd_mux[HW-1:0] = hash_stat;
            RS_HASH_EN:   rd_mux[HW-1:0] = hash_en;
            RS_DMA_STAT:  rd_mux[MW-1:0] = dma_stat;
            RS_DMA_EN:    rd_mux[MW-1:0] = dma_en;
            RS_DMA_UNMSK: rd_mux[0]      = unmask_q;
            default:      rd_mux         = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= rd ? rd_mux : '0;
    end

    assign irq = hash_pend || (dma_pend && unmask_q);
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BUS_W,
    parameter int HW = HASH_W,
    parameter int MW = DMA_W
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] hash_evt,
    input logic [MW-1:0] dma_evt,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic [HW-1:0] hash_stat,
    input logic [MW-1:0] dma_stat,
    input logic          unmask_q,
    input logic          hash_pend,
    input logic          irq
);
    logic hs_wr, ds_wr, rd_dma_stat, rd_unmapped;
    assign hs_wr       = bus_sel && bus_wr && (bus_addr == AW'(OFS_HASH_STAT));
    assign ds_wr       = bus_sel && bus_wr && (bus_addr == AW'(OFS_DMA_STAT));
    assign rd_dma_stat = bus_sel && !bus_wr && (bus_addr == AW'(OFS_DMA_STAT));
    assign rd_unmapped = bus_sel && !bus_wr && (decode_ofs(ADDR_W'(bus_addr)) == RS_NONE);

    // R2: without a status write, no latched bit ever falls
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !hs_wr |=> ((hash_stat & $past(hash_stat)) == $past(hash_stat)));

    // R3: reserved DMA status bits read as zero
    p_rsv_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rd_dma_stat |=> (bus_rdata[DW-1:MW] == '0 && bus_rdata[1] == 1'b0));

    // R4: clearing write without events removes exactly the written ones
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (hs_wr && hash_evt == '0) |=>
            hash_stat == ($past(hash_stat) & ~$past(bus_wdata[HW-1:0])));

    // R5: an event pulse always leaves its bit set, clear or not
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (ds_wr && dma_evt != '0) |=>
            ((dma_stat & $past(dma_evt & MW'(DMA_IMPL))) == $past(dma_evt & MW'(DMA_IMPL))));

    // R7: the line is only raised by a latched source
    p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (hash_stat != '0 || dma_stat != '0));

    // R8: with the DMA bank masked, only hash pending can raise irq
    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (!unmask_q && !hash_pend) |-> !irq);

    // R9: unmapped reads return zero
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        rd_unmapped |=> bus_rdata == '0);
endmodule

bind dual_irq_ctrl irqc_chk #(.AW(AW), .DW(DW), .HW(HW), .MW(MW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hash_evt (hash_evt),
    .dma_evt  (dma_evt),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .hash_stat(hash_stat),
    .dma_stat (dma_stat),
    .unmask_q (unmask_q),
    .hash_pend(hash_pend),
    .irq      (irq)
);

// File: tb/test_dual_irq_ctrl.sv
`timescale 1ns/1ps
module test_dual_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  hash_evt = '0;
    logic [8:0]  dma_evt = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    localparam logic [11:0] A_HS = 12'h050, A_HE = 12'h054;
    localparam logic [11:0] A_DS = 12'h480, A_DE = 12'h484, A_DM = 12'h488;

    always #5 clk = ~clk;

    dual_irq_ctrl i_dual_irq_ctrl (
        .clk(clk), .rst(rst), .hash_evt(hash_evt), .dma_evt(dma_evt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        rd_seen <= bus_sel && !bus_wr;
        cycles  <= cycles + 1;
    end

    // monitor: compare read data one cycle after each read request (R10)
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10: unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!done && cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles actual=%0d expected<20000", cycles);
            done = 1'b1;
            summary();
        end
    end

    task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input logic [3:0] he, input logic [8:0] de);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        hash_evt = he; dma_evt = de;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; hash_evt = '0; dma_evt = '0;
    endtask

    task automatic pulse(input logic [3:0] he, input logic [8:0] de);
        hash_evt = he; dma_evt = de;
        @(negedge clk);
        hash_evt = '0; dma_evt = '0;
    endtask

    task automatic check_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_irq(1'b0, "R1");
        do_read(A_HS, 32'h0, "R1");
        do_read(A_HE, 32'h0, "R1");
        do_read(A_DS, 32'h0, "R1");
        do_read(A_DE, 32'h0, "R1");
        do_read(A_DM, 32'h0, "R1");

        // R2 done event latches while disabled
        pulse(4'b0100, 9'h0);
        check_irq(1'b0, "R7 disabled");
        do_read(A_HS, 32'h4, "R2");
        do_read(A_HS, 32'h4, "R2 hold");

        // R6 enable readback, R7 irq rises
        do_write(A_HE, 32'hFFFF_FFFF, 4'h0, 9'h0);
        do_read(A_HE, 32'hF, "R6");
        check_irq(1'b1, "R7 hash");

        // R4 zero write keeps bits, one write clears
        do_write(A_HS, 32'h0, 4'h0, 9'h0);
        do_read(A_HS, 32'h4, "R4 zero write");
        do_write(A_HS, 32'h4, 4'h0, 9'h0);
        check_irq(1'b0, "R4 cleared");
        do_read(A_HS, 32'h0, "R4");

        // R3 DMA events, reserved bit 1
        pulse(4'h0, 9'h1FF);
        do_read(A_DS, 32'h1FD, "R3");

        // R8 masked, then unmasked
        do_write(A_DE, 32'hFFFF_FFFF, 4'h0, 9'h0);
        do_read(A_DE, 32'h1FD, "R6 dma");
        check_irq(1'b0, "R8 masked");
        do_write(A_DM, 32'hFFFF_FFFF, 4'h0, 9'h0);
        do_read(A_DM, 32'h1, "R8 readback");
        check_irq(1'b1, "R7 dma");

        // R6 enable zero disables bank
        do_write(A_DE, 32'h0, 4'h0, 9'h0);
        check_irq(1'b0, "R6 enable zero");
        do_read(A_DS, 32'h1FD, "R6 status kept");

        // R5 set wins over clear in same cycle
        do_write(A_DS, 32'hFFFF_FFFF, 4'h0, 9'h004);
        do_read(A_DS, 32'h004, "R5");
        do_write(A_DS, 32'hFFFF_FFFF, 4'h0, 9'h0);
        do_read(A_DS, 32'h0, "R4 all ones");

        // R9 unmapped offsets
        do_read(12'h058, 32'h0, "R9 read");
        do_write(12'h058, 32'h0, 4'h0, 9'h0);
        do_read(A_HE, 32'hF, "R9 write ignored");

        // R7 error bits, partial clear
        pulse(4'b1011, 9'h0);
        check_irq(1'b1, "R7 errors");
        do_write(A_HS, 32'h1, 4'h0, 9'h0);
        do_read(A_HS, 32'hA, "R4 partial");
        check_irq(1'b1, "R7 still pending");

        // R10 idle rdata is zero
        @(negedge clk);
        checks++;
        if (bus_rdata !== 32'h0) begin
            errors++;
            $display("FAIL R10: idle rdata actual=%h expected=0", bus_rdata);
        end
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R10: reads pending actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        summary();
    end
endmodule